// File: doc/BRIEF.md
# Refresh-Bounded Burst Splitter

This block takes one burst request and turns it into a series of smaller transfers (chunks). Each chunk is short enough that the memory device can keep its chip select low for the whole chunk and still get its refresh in time. The request names an element count and a power-of-two element size. The block multiplies these into a total byte length. It then issues chunks one at a time over a valid/ready handshake. Each chunk carries an external memory address, a buffer address and a byte length. Both addresses move forward by the chunk length before the next chunk is issued.

A chunk is limited by three values: the bytes still to move, a cap set by the requester, and a cap set by the device. The requester cap stops a low-priority client from holding the device long enough to starve a real-time client such as a video line fetch. The device cap is given as a byte budget for reads. The fixed command and latency overhead, expressed in bytes, is taken off that budget. For writes on a device whose write data rate is half its read rate, the result is also halved. Either cap may be zero, which means no limit, for example on a device with no refresh need. A one-cycle completion pulse follows the last chunk.

Top module: `burst_chunker`

## Requirements
- R1: The total byte length of a request is N × 2^S, where N is the 8-bit count field (a value of 0 means 256) and S is the 4-bit size exponent (0 to 15). The chunk lengths of one request add up to exactly this total, which is at most 8 MiB.
- R2: Each chunk length is the minimum of three values: the bytes still remaining, the requester cap, and the direction-adjusted device cap. A cap of zero means no limit. No chunk has length zero.
- R3: The direction-adjusted device cap is found in two steps. First, the device cap minus OVH_BYTES (default 8) is taken; a device cap at or below OVH_BYTES gives 1. Second, only when the request is a write and the half-rate flag is set, that value is halved, rounding down, with a floor of 1. Reads ignore the half-rate flag.
- R4: The first chunk uses the start addresses of the request. Each later chunk has external and buffer addresses equal to the previous chunk's addresses plus the previous chunk's length. The buffer address wraps modulo 2^BUF_W and the external address wraps modulo 2^EXT_W.
- R5: req_ready is high exactly when no request is in progress, and a request is accepted on a clock where req_valid and req_ready are both high. The first chunk is presented in the cycle after acceptance. chunk_valid stays high while any bytes remain. While chunk_ready is low, all chunk fields hold steady. After each accepted chunk, the next chunk appears in the following cycle.
- R6: chunk_last is high only on the final chunk. done is high for exactly one cycle, in the cycle after the final chunk is accepted, and req_ready is high in that same cycle.
- R7: While reset is asserted, req_ready is 1, chunk_valid is 0 and done is 0.
- R8: Raising req_valid while a request is in progress, with any field values, leaves the chunk sequence of that request unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Splitter idle, request can be taken |
| req_ext_addr | input | EXT_W (28) | External start address (bank and offset) |
| req_buf_addr | input | BUF_W (20) | Buffer start address |
| req_count | input | CNT_W (8) | Element count, 0 means 256 |
| req_size | input | SZ_W (4) | Element size exponent, bytes = 2^value |
| req_cap | input | LEN_W (24) | Requester chunk cap in bytes, 0 = none |
| dev_cap | input | LEN_W (24) | Device read budget in bytes, 0 = none |
| req_write | input | 1 | 1 = write, 0 = read |
| wr_half_rate | input | 1 | Write data rate is half the read rate |
| chunk_valid | output | 1 | Chunk fields valid |
| chunk_ready | input | 1 | Chunk taken by the bus engine |
| chunk_ext_addr | output | EXT_W (28) | External address of this chunk |
| chunk_buf_addr | output | BUF_W (20) | Buffer address of this chunk |
| chunk_len | output | LEN_W (24) | Chunk length in bytes |
| chunk_last | output | 1 | Final chunk of the request |
| done | output | 1 | One-cycle pulse after the final chunk |

## Verification
The assertions assume the following about the request side:
- The request fields are only meaningful while req_valid is high together with req_ready.
- chunk_ready may toggle freely from cycle to cycle.

The assertions do not assume chunk_ready is ever held high.

The stimulus follows these assumptions as follows:
- It changes inputs only just after a rising edge.
- It holds a request for one accepting edge.
- It raises req_valid with unrelated field values while a burst is running, but only on bursts long enough that the intruding request is dropped before the running request finishes.
- It drives chunk_ready with always-high, alternating and one-in-three-low patterns, so that the hold-while-stalled properties see real stalls.

// File: rtl/bsplit_pkg.sv
`timescale 1ns/1ps
package bsplit_pkg;

   typedef enum logic [0:0] {
      BS_IDLE = 1'b0,
      BS_RUN  = 1'b1
   } bs_state_e;

   localparam int DEF_EXT_W = 28;
   localparam int DEF_BUF_W = 20;
   localparam int DEF_CNT_W = 8;
   localparam int DEF_SZ_W  = 4;
   localparam int DEF_LEN_W = 24;

endpackage

// File: rtl/bsplit_total.sv
`timescale 1ns/1ps
// Converts element count and size exponent into a byte total with a
// staged shifter: one conditional shift stage per exponent bit.
module bsplit_total #(
   parameter int CNT_W = bsplit_pkg::DEF_CNT_W,
   parameter int SZ_W  = bsplit_pkg::DEF_SZ_W,
   parameter int LEN_W = bsplit_pkg::DEF_LEN_W
) (
   input  logic [CNT_W-1:0] xfer_cnt,
   input  logic [SZ_W-1:0]  elem_log2,
   output logic [LEN_W-1:0] total_len
);
   localparam int MAX_SHIFT = (1 << SZ_W) - 1;
   localparam int NEED_W    = CNT_W + 1 + MAX_SHIFT;

   initial begin
      assert (LEN_W >= NEED_W)
         else $error("bsplit_total: LEN_W %0d too small, need %0d", LEN_W, NEED_W);
   end

   logic [CNT_W:0]   n_elem;
   logic [LEN_W-1:0] stage [SZ_W+1];

   // a zero count stands for the full 2^CNT_W elements
   always_comb begin
      if (xfer_cnt == '0) n_elem = {1'b1, {CNT_W{1'b0}}};
      else                n_elem = {1'b0, xfer_cnt};
   end

   assign stage[0] = LEN_W'(n_elem);

   for (genvar s = 0; s < SZ_W; s++) begin : g_shift
      assign stage[s+1] = elem_log2[s] ? (stage[s] << (1 << s)) : stage[s];
   end

   assign total_len = stage[SZ_W];

endmodule

// File: rtl/bsplit_cap.sv
`timescale 1ns/1ps
// Chunk length selection: remaining bytes against requester cap and
// the overhead-reduced, direction-scaled device budget.
module bsplit_cap #(
   parameter int LEN_W      = bsplit_pkg::DEF_LEN_W,
   parameter int OVH_BYTES  = 8,
   parameter bit SLOW_WR_EN = 1'b1
) (
   input  logic [LEN_W-1:0] remain,
   input  logic [LEN_W-1:0] rq_cap,
   input  logic [LEN_W-1:0] dv_cap,
   input  logic             is_wr,
   input  logic             wr_slow,
   output logic [LEN_W-1:0] chunk_len
);
   localparam logic [LEN_W-1:0] OVH = LEN_W'(OVH_BYTES);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   initial begin
      assert (OVH_BYTES >= 0 && OVH_BYTES < (1 << (LEN_W - 1)))
         else $error("bsplit_cap: OVH_BYTES %0d out of range", OVH_BYTES);
   end

   logic [LEN_W-1:0] dev_net;
   logic [LEN_W-1:0] dev_dir;
   logic [LEN_W-1:0] dev_lim;
   logic [LEN_W-1:0] rq_lim;
   logic [LEN_W-1:0] cap_min;

   // command and latency time removed from the budget
   always_comb begin
      if (dv_cap > OVH) dev_net = dv_cap - OVH;
      else              dev_net = ONE;
   end

   if (SLOW_WR_EN) begin : g_slow_wr
      logic [LEN_W-1:0] halved;
      always_comb begin
         halved = dev_net >> 1;
         if (halved == '0) halved = ONE;
         dev_dir = (is_wr && wr_slow) ? halved : dev_net;
      end
   end else begin : g_even_rate
      logic unused_dir;
      assign unused_dir = is_wr ^ wr_slow;
      assign dev_dir    = dev_net;
   end

   always_comb begin
      dev_lim = (dv_cap == '0) ? '1 : dev_dir;
      rq_lim  = (rq_cap == '0) ? '1 : rq_cap;
      cap_min = (rq_lim < dev_lim) ? rq_lim : dev_lim;
      chunk_len = (remain < cap_min) ? remain : cap_min;
   end

endmodule

// File: rtl/bsplit_seq.sv
`timescale 1ns/1ps
// Request capture, address/length bookkeeping and chunk handshake.
module bsplit_seq import bsplit_pkg::*; #(
   parameter int EXT_W = DEF_EXT_W,
   parameter int BUF_W = DEF_BUF_W,
   parameter int LEN_W = DEF_LEN_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [EXT_W-1:0] req_ext,
   input  logic [BUF_W-1:0] req_buf,
   input  logic [LEN_W-1:0] req_total,
   input  logic [LEN_W-1:0] req_rcap,
   input  logic [LEN_W-1:0] req_dcap,
   input  logic             req_wr,
   input  logic             req_slow,
   output logic [LEN_W-1:0] q_rem,
   output logic [LEN_W-1:0] q_rcap,
   output logic [LEN_W-1:0] q_dcap,
   output logic             q_wr,
   output logic             q_slow,
   input  logic [LEN_W-1:0] cur_len,
   output logic             chunk_valid,
   input  logic             chunk_ready,
   output logic [EXT_W-1:0] chunk_ext_addr,
   output logic [BUF_W-1:0] chunk_buf_addr,
   output logic             chunk_last,
   output logic             done
);
   initial begin
      assert (EXT_W >= LEN_W)
         else $error("bsplit_seq: EXT_W %0d below LEN_W %0d", EXT_W, LEN_W);
      assert (BUF_W > 0)
         else $error("bsplit_seq: BUF_W must be positive");
   end

   bs_state_e        state_q;
   logic [EXT_W-1:0] ext_q;
   logic [BUF_W-1:0] buf_q;
   logic [LEN_W-1:0] rem_q;
   logic [LEN_W-1:0] rcap_q;
   logic [LEN_W-1:0] dcap_q;
   logic             wr_q;
   logic             slow_q;
   logic             done_q;
   logic             running;
   logic             accept;
   logic             fire;
   logic             final_c;

   assign running = (state_q == BS_RUN);
   assign accept  = !running && req_valid;
   assign fire    = running && chunk_ready;
   assign final_c = (cur_len == rem_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= BS_IDLE;
         ext_q   <= '0;
         buf_q   <= '0;
         rem_q   <= '0;
         rcap_q  <= '0;
         dcap_q  <= '0;
         wr_q    <= 1'b0;
         slow_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            ext_q   <= req_ext;
            buf_q   <= req_buf;
            rem_q   <= req_total;
            rcap_q  <= req_rcap;
            dcap_q  <= req_dcap;
            wr_q    <= req_wr;
            slow_q  <= req_slow;
            state_q <= BS_RUN;
         end else if (fire) begin
            ext_q <= ext_q + EXT_W'(cur_len);
            buf_q <= buf_q + BUF_W'(cur_len);
            rem_q <= rem_q - cur_len;
            if (final_c) begin
               state_q <= BS_IDLE;
               done_q  <= 1'b1;
            end
         end
      end
   end

   assign req_ready      = !running;
   assign chunk_valid    = running;
   assign chunk_ext_addr = ext_q;
   assign chunk_buf_addr = buf_q;
   assign chunk_last     = running && final_c;
   assign done           = done_q;
   assign q_rem          = rem_q;
   assign q_rcap         = rcap_q;
   assign q_dcap         = dcap_q;
   assign q_wr           = wr_q;
   assign q_slow         = slow_q;

   AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      chunk_valid |-> (cur_len != '0) && (cur_len <= rem_q)); // R2

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      chunk_valid && !chunk_ready |=> chunk_valid && $stable(chunk_ext_addr)
         && $stable(chunk_buf_addr) && $stable(cur_len)); // R5

   AST_EXT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      chunk_valid && chunk_ready && !chunk_last |=>
         chunk_ext_addr == EXT_W'($past(chunk_ext_addr) + EXT_W'($past(cur_len)))); // R4

   AST_BUF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      chunk_valid && chunk_ready && !chunk_last |=>
         chunk_buf_addr == BUF_W'($past(chunk_buf_addr) + BUF_W'($past(cur_len)))); // R4

   AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      chunk_valid |-> !req_ready); // R5

   AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      chunk_valid && chunk_ready && chunk_last |=> done && req_ready); // R6

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6

endmodule

// File: rtl/burst_chunker.sv
`timescale 1ns/1ps
module burst_chunker #(
   parameter int EXT_W      = 28,
   parameter int BUF_W      = 20,
   parameter int CNT_W      = 8,
   parameter int SZ_W       = 4,
   parameter int LEN_W      = 24,
   parameter int OVH_BYTES  = 8,
   parameter bit SLOW_WR_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [EXT_W-1:0] req_ext_addr,
   input  logic [BUF_W-1:0] req_buf_addr,
   input  logic [CNT_W-1:0] req_count,
   input  logic [SZ_W-1:0]  req_size,
   input  logic [LEN_W-1:0] req_cap,
   input  logic [LEN_W-1:0] dev_cap,
   input  logic             req_write,
   input  logic             wr_half_rate,
   output logic             chunk_valid,
   input  logic             chunk_ready,
   output logic [EXT_W-1:0] chunk_ext_addr,
   output logic [BUF_W-1:0] chunk_buf_addr,
   output logic [LEN_W-1:0] chunk_len,
   output logic             chunk_last,
   output logic             done
);
   logic [LEN_W-1:0] total_len;
   logic [LEN_W-1:0] q_rem;
   logic [LEN_W-1:0] q_rcap;
   logic [LEN_W-1:0] q_dcap;
   logic             q_wr;
   logic             q_slow;
   logic [LEN_W-1:0] sel_len;

   bsplit_total #(
      .CNT_W (CNT_W),
      .SZ_W  (SZ_W),
      .LEN_W (LEN_W)
   ) u_total (
      .xfer_cnt  (req_count),
      .elem_log2 (req_size),
      .total_len (total_len)
   );

   bsplit_seq #(
      .EXT_W (EXT_W),
      .BUF_W (BUF_W),
      .LEN_W (LEN_W)
   ) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_ready      (req_ready),
      .req_ext        (req_ext_addr),
      .req_buf        (req_buf_addr),
      .req_total      (total_len),
      .req_rcap       (req_cap),
      .req_dcap       (dev_cap),
      .req_wr         (req_write),
      .req_slow       (wr_half_rate),
      .q_rem          (q_rem),
      .q_rcap         (q_rcap),
      .q_dcap         (q_dcap),
      .q_wr           (q_wr),
      .q_slow         (q_slow),
      .cur_len        (sel_len),
      .chunk_valid    (chunk_valid),
      .chunk_ready    (chunk_ready),
      .chunk_ext_addr (chunk_ext_addr),
      .chunk_buf_addr (chunk_buf_addr),
      .chunk_last     (chunk_last),
      .done           (done)
   );

   bsplit_cap #(
      .LEN_W      (LEN_W),
      .OVH_BYTES  (OVH_BYTES),
      .SLOW_WR_EN (SLOW_WR_EN)
   ) u_cap (
      .remain    (q_rem),
      .rq_cap    (q_rcap),
      .dv_cap    (q_dcap),
      .is_wr     (q_wr),
      .wr_slow   (q_slow),
      .chunk_len (sel_len)
   );

   assign chunk_len = sel_len;

   AST_REQ_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      chunk_valid && (q_rcap != '0) |-> chunk_len <= q_rcap); // R2

   AST_DEV_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
      chunk_valid && (q_dcap > LEN_W'(OVH_BYTES)) |->
         chunk_len <= q_dcap - LEN_W'(OVH_BYTES)); // R3

endmodule

// File: tb/sim_burst_chunker.sv
`timescale 1ns/1ps
module sim_burst_chunker;
   localparam int EXTW = 28;
   localparam int BUFW = 20;
   localparam int CNTW = 8;
   localparam int SZW  = 4;
   localparam int LENW = 24;
   localparam int OVH  = 8;
   localparam longint EXT_MASK = (64'd1 << EXTW) - 1;
   localparam longint BUF_MASK = (64'd1 << BUFW) - 1;
   localparam longint BIG      = 64'h7FFF_FFFF_FFFF;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic            req_ready;
   logic [EXTW-1:0] req_ext_addr = '0;
   logic [BUFW-1:0] req_buf_addr = '0;
   logic [CNTW-1:0] req_count = '0;
   logic [SZW-1:0]  req_size = '0;
   logic [LENW-1:0] req_cap = '0;
   logic [LENW-1:0] dev_cap = '0;
   logic            req_write = 1'b0;
   logic            wr_half_rate = 1'b0;
   logic            chunk_valid;
   logic            chunk_ready = 1'b0;
   logic [EXTW-1:0] chunk_ext_addr;
   logic [BUFW-1:0] chunk_buf_addr;
   logic [LENW-1:0] chunk_len;
   logic            chunk_last;
   logic            done;

   burst_chunker #(
      .EXT_W(EXTW), .BUF_W(BUFW), .CNT_W(CNTW), .SZ_W(SZW),
      .LEN_W(LENW), .OVH_BYTES(OVH), .SLOW_WR_EN(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_ext_addr(req_ext_addr), .req_buf_addr(req_buf_addr),
      .req_count(req_count), .req_size(req_size), .req_cap(req_cap),
      .dev_cap(dev_cap), .req_write(req_write), .wr_half_rate(wr_half_rate),
      .chunk_valid(chunk_valid), .chunk_ready(chunk_ready),
      .chunk_ext_addr(chunk_ext_addr), .chunk_buf_addr(chunk_buf_addr),
      .chunk_len(chunk_len), .chunk_last(chunk_last), .done(done)
   );

   always #2.5 clk = ~clk;

   int n_checks = 0;
   int n_fail   = 0;
   int ready_mode = 0;
   int cyc = 0;
   bit finished = 1'b0;

   // behavioural reference state
   bit     m_busy = 1'b0;
   bit     m_done = 1'b0;
   bit     m_wr, m_slow;
   longint m_ext, m_buf, m_rem, m_rcap, m_dcap, m_total;
   longint dut_sum = 0;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   function automatic longint exp_len();
      longint rl, dl, b, m;
      rl = (m_rcap == 0) ? BIG : m_rcap;
      if (m_dcap == 0) dl = BIG;
      else begin
         b = (m_dcap > OVH) ? m_dcap - OVH : 1;
         if (m_wr && m_slow) begin
            b = b / 2;
            if (b == 0) b = 1;
         end
         dl = b;
      end
      m = (rl < dl) ? rl : dl;
      return (m_rem < m) ? m_rem : m;
   endfunction

   // reference model advances on the same edge as the design
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_busy = 1'b0;
         m_done = 1'b0;
      end else begin
         m_done = 1'b0;
         if (m_busy) begin
            if (chunk_ready) begin
               longint l;
               l = exp_len();
               m_ext = (m_ext + l) & EXT_MASK;
               m_buf = (m_buf + l) & BUF_MASK;
               m_rem = m_rem - l;
               if (m_rem == 0) begin
                  m_busy = 1'b0;
                  m_done = 1'b1;
               end
            end
         end else if (req_valid) begin
            longint n;
            n       = (req_count == 0) ? 256 : longint'(req_count);
            m_total = n << req_size;
            m_rem   = m_total;
            m_ext   = longint'(req_ext_addr);
            m_buf   = longint'(req_buf_addr);
            m_rcap  = longint'(req_cap);
            m_dcap  = longint'(dev_cap);
            m_wr    = req_write;
            m_slow  = wr_half_rate;
            m_busy  = 1'b1;
         end
      end
   end

   // comparison away from the active edge
   always @(negedge clk) begin
      if (!finished) begin
         if (!rst_n) begin
            chk("R7", "req_ready in reset", longint'(req_ready), 1);
            chk("R7", "chunk_valid in reset", longint'(chunk_valid), 0);
            chk("R7", "done in reset", longint'(done), 0);
         end else begin
            chk("R5", "req_ready", longint'(req_ready), longint'(!m_busy));
            chk("R5", "chunk_valid", longint'(chunk_valid), longint'(m_busy));
            chk("R6", "done", longint'(done), longint'(m_done));
            if (m_busy) begin
               chk("R2 R3", "chunk_len", longint'(chunk_len), exp_len());
               chk("R4", "chunk_ext_addr", longint'(chunk_ext_addr), m_ext);
               chk("R4", "chunk_buf_addr", longint'(chunk_buf_addr), m_buf);
               chk("R6", "chunk_last", longint'(chunk_last), longint'(exp_len() == m_rem));
               if (chunk_valid && chunk_ready) begin
                  dut_sum = dut_sum + longint'(chunk_len);
                  if (chunk_last) begin
                     chk("R1", "sum of chunk lengths", dut_sum, m_total);
                     dut_sum = 0;
                  end
               end
            end
         end
      end
   end

   // chunk_ready pattern driver
   initial begin
      forever begin
         @(posedge clk);
         #1;
         case (ready_mode)
            0:       chunk_ready = 1'b1;
            1:       chunk_ready = cyc[0];
            default: chunk_ready = (cyc % 3) != 0;
         endcase
      end
   end

   task automatic run_req(input int cnt, input int sz, input longint ext, input longint bufa,
                          input longint rcap, input longint dcap, input bit wr, input bit slow,
                          input int rmode, input bit poke);
      @(posedge clk);
      #1;
      ready_mode   = rmode;
      req_count    = CNTW'(cnt);
      req_size     = SZW'(sz);
      req_ext_addr = EXTW'(ext);
      req_buf_addr = BUFW'(bufa);
      req_cap      = LENW'(rcap);
      dev_cap      = LENW'(dcap);
      req_write    = wr;
      wr_half_rate = slow;
      req_valid    = 1'b1;
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      if (poke) begin
         // R8: intruding request while busy must be ignored
         req_valid    = 1'b1;
         req_count    = 8'd3;
         req_size     = 4'd1;
         req_ext_addr = 28'h0ABCDEF;
         req_buf_addr = 20'h12345;
         req_cap      = 24'd2;
         dev_cap      = 24'd0;
         req_write    = ~wr;
         repeat (3) @(posedge clk);
         #1;
         req_valid = 1'b0;
      end
      @(negedge clk);
      while (m_busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      // R1: 640 bytes as 80 x 8, one chunk
      run_req(80, 3, 28'h0001000, 20'h00100, 0, 0, 1'b0, 1'b0, 0, 1'b0);
      // R2: requester cap 256 on 1920 bytes, stalled handshake
      run_req(240, 3, 28'h0200000, 20'h04000, 256, 0, 1'b0, 1'b0, 1, 1'b1);
      // R3: device budget 200 read -> 192
      run_req(120, 4, 28'h0300010, 20'h08000, 0, 200, 1'b0, 1'b0, 2, 1'b1);
      // R3: half-rate write -> 96
      run_req(120, 4, 28'h0300010, 20'h08000, 0, 200, 1'b1, 1'b1, 0, 1'b1);
      // R3: write at full rate -> 192
      run_req(120, 4, 28'h0400000, 20'h00000, 0, 200, 1'b1, 1'b0, 1, 1'b0);
      // R3: read ignores half-rate flag -> 192
      run_req(120, 4, 28'h0400000, 20'h00000, 0, 200, 1'b0, 1'b1, 0, 1'b0);
      // R1 R3: count 0 = 256 bytes, budget under overhead -> 1-byte chunks
      run_req(0, 0, 28'h0500000, 20'h00010, 0, 5, 1'b1, 1'b1, 0, 1'b1);
      // R3: budget 10 half-rate write -> 1
      run_req(4, 1, 28'h0500100, 20'h00020, 0, 10, 1'b1, 1'b1, 0, 1'b0);
      // R4: address wrap on both sides, mixed caps
      run_req(1, 15, 28'hFFFF000, 20'hFF000, 4096, 1000, 1'b0, 1'b0, 2, 1'b1);
      // R1: largest burst in one chunk
      run_req(0, 15, 28'h1000000, 20'h00000, 0, 0, 1'b0, 1'b0, 0, 1'b0);
      // R2: largest burst split by requester cap
      run_req(0, 15, 28'h1000000, 20'h00040, 24'h100000, 0, 1'b1, 1'b0, 1, 1'b1);
      // R2: requester cap smaller than device budget
      run_req(30, 6, 28'h0600000, 20'h00400, 100, 300, 1'b0, 1'b0, 2, 1'b1);
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL R6 watchdog: actual running expected finished");
      finished = 1'b1;
      summary();
      $finish;
   end

endmodule